// File: doc/BRIEF.md
# Cyclic Frame Task Sequencer

This block is a time-triggered dispatcher. A free-running tick counter cuts time into frames whose length in clock cycles is set by an input. At the start of every frame the block looks up the entry for the current frame index in a schedule table fixed at elaboration. If the entry names a task, the block raises a one-cycle start strobe carrying the task code. The frame index then advances modulo the table length, so the schedule repeats without end.

Each task reports completion with a done pulse on its own bit. If the task dispatched in a frame has not reported done by the next frame boundary, a sticky overrun flag is set, and the next entry is still dispatched on time. A watchdog supervises one chosen task. It keeps a completion flag that the task's done pulse sets. Once every nine frames it inspects the flag: a clear flag raises a sticky response-time alarm, and the flag is then cleared for the next window.

The dispatcher is a three-state machine. ST_BOOT waits for the first frame boundary after reset. ST_BUSY means the task of the current frame is outstanding. ST_FREE means the current frame is idle or its task has finished. Its transitions are:
- boot-to-busy or boot-to-free on the first tick, picked by whether the entry is idle.
- busy-to-free on a matching done pulse with no tick.
- busy-to-busy or busy-to-free on a tick. This transition records an overrun.
- free-to-busy or free-to-free on a tick.

The watchdog has two states. WD_ARMING lasts until the first tick. WD_WATCH then counts frames between checks.

Top module: `cyclic_frame_sequencer`

## Requirements
- R1: Reset clears start_vld, overrun and wd_alarm, sets the frame index to 0 and clears the watchdog flag. The first start strobe follows the first tick after reset and carries the frame-0 entry.
- R2: A tick occurs every max(frame_len, 2) cycles. With reset released at cycle 0, the first strobe is visible after clock edge frame_len. Each strobe is high for exactly one cycle, and strobes occur only at frame starts.
- R3: The frame index advances by one at every tick and wraps from NUM_FRAMES-1 to 0, so the dispatched sequence repeats with period NUM_FRAMES.
- R4: Task codes are 0 idle, 1 sample, 2 compute, 3 control, 4 telemetry part 1, 5 telemetry part 2 and 6 self-test. The default 15-entry table, frames 0 to 14, is 1,2,3,4,6,1,2,3,5,4,1,2,3,5,6.
- R5: A frame whose entry is code 0 produces no start strobe and cannot cause an overrun.
- R6: If a tick arrives while the task dispatched in the previous frame has not reported done, overrun is set. It stays set until reset, and the new entry is still dispatched at that tick.
- R7: Code c reports done on task_done bit c-1. A done pulse on any other bit has no effect on the current task's outstanding state.
- R8: The watchdog checks at every ninth tick after the first tick, that is at ticks 10, 19, 28 and so on. The supervised task's done bit (default sample, bit 0) sets the completion flag.
- R9: At a check, wd_alarm is set if the flag is clear, counting a done pulse in the same cycle. The alarm stays set until reset, and the flag is cleared at every check.
- R10: start_id holds the last dispatched code between strobes, including through idle frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_len | input | CNT_W | Frame length in cycles; values below 2 act as 2 |
| task_done | input | NUM_TASKS | Done pulses; bit c-1 belongs to task code c |
| start_vld | output | 1 | One-cycle task start strobe |
| start_id | output | 3 | Code of the dispatched task |
| overrun | output | 1 | Sticky frame overrun flag |
| wd_alarm | output | 1 | Sticky response-time alarm |

## Verification
A frame index that is off by one, or that wraps at the wrong count, shows as a wrong start_id at the very next strobe. That error repeats once per table period. A state machine stuck in ST_BUSY or ST_FREE shows at the following tick as an overrun that should or should not be there, so at most one frame late. A watchdog counter or flag fault stays hidden until the next check, up to nine frames later. The test therefore skips the supervised task's completions across exactly one window and looks for the alarm at that check and not one check early.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int ID_W       = 3;
    localparam int NUM_TASKS  = 6;
    localparam int DEF_FRAMES = 15;

    typedef enum logic [ID_W-1:0] {
        T_IDLE     = 3'd0,
        T_SAMPLE   = 3'd1,
        T_COMPUTE  = 3'd2,
        T_CONTROL  = 3'd3,
        T_TELEM_A  = 3'd4,
        T_TELEM_B  = 3'd5,
        T_SELFTEST = 3'd6
    } task_code_e;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_BUSY,
        ST_FREE
    } disp_state_e;

    typedef enum logic {
        WD_ARMING,
        WD_WATCH
    } wd_state_e;

    // Three control-loop tasks every five frames; the last two slots of each
    // group of five carry the background tasks.
    function automatic task_code_e default_entry(input int idx);
        task_code_e c;
        case (idx % 5)
            0:       c = T_SAMPLE;
            1:       c = T_COMPUTE;
            2:       c = T_CONTROL;
            3:       c = (idx == 3) ? T_TELEM_A : T_TELEM_B;
            default: c = (idx == 9) ? T_TELEM_A : T_SELFTEST;
        endcase
        return c;
    endfunction

    function automatic logic [DEF_FRAMES*ID_W-1:0] default_table();
        logic [DEF_FRAMES*ID_W-1:0] t;
        t = '0;
        for (int i = 0; i < DEF_FRAMES; i++) begin
            t[i*ID_W +: ID_W] = default_entry(i);
        end
        return t;
    endfunction

endpackage

// File: rtl/fsq_frame_timer.sv
module fsq_frame_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] frame_len,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   limit;
    logic [CNT_W:0]   next_cnt;

    always_comb begin
        limit    = (frame_len < CNT_W'(2)) ? (CNT_W+1)'(2) : {1'b0, frame_len};
        next_cnt = {1'b0, cnt} + (CNT_W+1)'(1);
        tick     = (next_cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fsq_sched_rom.sv
module fsq_sched_rom import fsq_pkg::*; #(
    parameter int NUM_FRAMES = 15,
    parameter logic [NUM_FRAMES*ID_W-1:0] TABLE = '0,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output task_code_e       code
);

    task_code_e entry [NUM_FRAMES];

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_ent
        assign entry[g] = task_code_e'(TABLE[g*ID_W +: ID_W]);
    end

    always_comb begin
        code = T_IDLE;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if (int'(idx) == i) code = entry[i];
        end
    end

endmodule

// File: rtl/fsq_dispatch.sv
module fsq_dispatch import fsq_pkg::*; #(
    parameter int NUM_FRAMES = 15,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  task_code_e           code,
    input  logic [NUM_TASKS-1:0] task_done,
    output logic [IDX_W-1:0]     idx,
    output logic                 start_vld,
    output logic [ID_W-1:0]      start_id,
    output logic                 overrun
);

    disp_state_e          state, state_nx;
    task_code_e           cur_task;
    logic [NUM_TASKS-1:0] sel_mask;
    logic                 done_hit;
    disp_state_e          on_tick;

    always_comb begin
        sel_mask = '0;
        if (cur_task != T_IDLE) begin
            sel_mask = NUM_TASKS'(1) << (int'(cur_task) - 1);
        end
        done_hit = |(task_done & sel_mask);
        on_tick  = (code == T_IDLE) ? ST_FREE : ST_BUSY;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT: if (tick) state_nx = on_tick;
            ST_BUSY: begin
                if (tick)          state_nx = on_tick;
                else if (done_hit) state_nx = ST_FREE;
            end
            ST_FREE: if (tick) state_nx = on_tick;
            default: state_nx = ST_BOOT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_nx;
    end

    // outputs and frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            start_vld <= 1'b0;
            start_id  <= '0;
            overrun   <= 1'b0;
            cur_task  <= T_IDLE;
        end else begin
            start_vld <= 1'b0;
            if (tick) begin
                start_vld <= (code != T_IDLE);
                if (code != T_IDLE) start_id <= code;
                cur_task <= code;
                idx <= (int'(idx) == NUM_FRAMES-1) ? '0 : idx + IDX_W'(1);
                if (state == ST_BUSY && !done_hit) overrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fsq_watchdog.sv
module fsq_watchdog import fsq_pkg::*; #(
    parameter int WD_FRAMES = 9,
    localparam int WD_W = (WD_FRAMES > 1) ? $clog2(WD_FRAMES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sup_done,
    output logic alarm
);

    wd_state_e       state, state_nx;
    logic [WD_W-1:0] cnt;
    logic            seen;
    logic            check_now;

    always_comb begin
        state_nx = state;
        unique case (state)
            WD_ARMING: if (tick) state_nx = WD_WATCH;
            WD_WATCH:  state_nx = WD_WATCH;
            default:   state_nx = WD_ARMING;
        endcase
        check_now = (state == WD_WATCH) && tick && (cnt == WD_W'(WD_FRAMES-1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_ARMING;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            seen  <= 1'b0;
            alarm <= 1'b0;
        end else begin
            if (check_now) begin
                if (!(seen || sup_done)) alarm <= 1'b1;
                seen <= 1'b0;
                cnt  <= '0;
            end else begin
                seen <= seen | sup_done;
                if (state == WD_WATCH && tick) cnt <= cnt + WD_W'(1);
            end
        end
    end

endmodule

// File: rtl/cyclic_frame_sequencer.sv
module cyclic_frame_sequencer import fsq_pkg::*; #(
    parameter int CNT_W      = 16,
    parameter int NUM_FRAMES = DEF_FRAMES,
    parameter logic [NUM_FRAMES*ID_W-1:0] TABLE = default_table(),
    parameter int WD_FRAMES  = 9,
    parameter int SUP_TASK   = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     frame_len,
    input  logic [NUM_TASKS-1:0] task_done,
    output logic                 start_vld,
    output logic [ID_W-1:0]      start_id,
    output logic                 overrun,
    output logic                 wd_alarm
);

    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

    logic             tick;
    logic [IDX_W-1:0] cur_idx;
    task_code_e       cur_code;

    fsq_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_len (frame_len),
        .tick      (tick)
    );

    fsq_sched_rom #(.NUM_FRAMES(NUM_FRAMES), .TABLE(TABLE)) u_rom (
        .idx  (cur_idx),
        .code (cur_code)
    );

    fsq_dispatch #(.NUM_FRAMES(NUM_FRAMES)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .code      (cur_code),
        .task_done (task_done),
        .idx       (cur_idx),
        .start_vld (start_vld),
        .start_id  (start_id),
        .overrun   (overrun)
    );

    fsq_watchdog #(.WD_FRAMES(WD_FRAMES)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sup_done (task_done[SUP_TASK-1]),
        .alarm    (wd_alarm)
    );

endmodule

// File: rtl/cyclic_frame_sequencer_chk.sv
module cyclic_frame_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       start_vld,
    input logic [2:0] start_id,
    input logic       overrun,
    input logic       wd_alarm
);

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |=> !start_vld);

    // R2
    strobe_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |-> $past(tick));

    // R5
    no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |-> (start_id != 3'd0));

    // R10
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(start_id) |-> start_vld);

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R6
    overrun_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(tick));

    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_alarm |=> wd_alarm);

    // R8
    alarm_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_alarm) |-> $past(tick));

endmodule

bind cyclic_frame_sequencer cyclic_frame_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start_vld (start_vld),
    .start_id  (start_id),
    .overrun   (overrun),
    .wd_alarm  (wd_alarm)
);

// File: tb/cyclic_frame_sequencer_bench.sv
`timescale 1ns/1ps
module cyclic_frame_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] frame_len;
    logic [5:0]  task_done;
    logic [5:0]  alt_done = 6'h3f;

    logic        start_vld, overrun, wd_alarm;
    logic [2:0]  start_id;
    logic        alt_vld, alt_ovr, alt_alarm;
    logic [2:0]  alt_id;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cyclic_frame_sequencer u_cyclic_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .task_done(task_done),
        .start_vld(start_vld), .start_id(start_id), .overrun(overrun), .wd_alarm(wd_alarm)
    );

    // 3-frame table: frame0 compute, frame1 idle, frame2 sample
    cyclic_frame_sequencer #(.NUM_FRAMES(3), .TABLE(9'b001_000_010)) u_cyclic_frame_sequencer_alt (
        .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .task_done(alt_done),
        .start_vld(alt_vld), .start_id(alt_id), .overrun(alt_ovr), .wd_alarm(alt_alarm)
    );

    // default schedule, frames 0..14 (R4)
    localparam int EXP_ID [15] = '{1,2,3,4,6,1,2,3,5,4,1,2,3,5,6};
    // per strobe: 0 no done, 1 done of the dispatched task, 2 done on another task's bit
    localparam int VEC_DONE [30] = '{1,1,1,1,1,1,1,2,1,1,
                                     1,1,1,1,1,1,1,1,1,1,
                                     0,1,1,1,1,0,1,1,1,1};

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!start_vld && n < 100);
        if (!start_vld) check(req, 0, 1);
    endtask

    task automatic do_reset(input int len);
        @(negedge clk);
        rst_n     = 1'b0;
        frame_len = 16'(len);
        task_done = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int c0, last, exp_id, prev_id, prev_dn, gap;
        bit ovr_exp, alarm_exp, flag;
        int alt_ids [8];
        int alt_n;

        rst_n = 1'b0; frame_len = 16'd4; task_done = '0;
        do_reset(4);
        // R1 reset state
        check("R1 start_vld in reset", int'(start_vld), 0);
        check("R1 overrun in reset", int'(overrun), 0);
        check("R1 wd_alarm in reset", int'(wd_alarm), 0);
        rst_n = 1'b1;
        c0 = cyc;

        ovr_exp = 0; alarm_exp = 0; flag = 0; prev_id = 0; prev_dn = 1; last = c0;
        for (int k = 0; k < 30; k++) begin
            wait_strobe("R2 strobe missing");
            exp_id = EXP_ID[k % 15];
            gap = cyc - last;
            last = cyc;
            check(k == 0 ? "R1 first strobe cycle" : "R2 frame spacing", gap, 4);
            if (k > 0 && prev_id != 0 && prev_dn != 1) ovr_exp = 1;
            if (k > 0 && (k % 9) == 0) begin
                if (!flag) alarm_exp = 1;
                flag = 0;
            end
            check(k == 0 ? "R1 frame0 entry" : "R3 R4 task id", int'(start_id), exp_id);
            check(k == 8 ? "R7 foreign done ignored" : "R6 overrun", int'(overrun), int'(ovr_exp));
            check((k == 26 || k == 27) ? "R8 R9 alarm at check" : "R9 alarm", int'(wd_alarm), int'(alarm_exp));
            if (VEC_DONE[k] == 1) task_done = 6'(1) << (exp_id - 1);
            if (VEC_DONE[k] == 2) task_done = 6'(1) << (exp_id % 6);
            if (VEC_DONE[k] == 1 && exp_id == 1) flag = 1;
            prev_id = exp_id;
            prev_dn = VEC_DONE[k];
            @(negedge clk);
            task_done = '0;
            check("R2 strobe width", int'(start_vld), 0);
            check("R10 id hold", int'(start_id), exp_id);
        end

        // mid-run reset with a longer frame (R1, R2)
        do_reset(7);
        check("R1 overrun cleared", int'(overrun), 0);
        check("R1 alarm cleared", int'(wd_alarm), 0);
        check("R1 strobe cleared", int'(start_vld), 0);
        rst_n = 1'b1;
        last = cyc;
        for (int k = 0; k < 2; k++) begin
            wait_strobe("R2 strobe missing");
            check("R2 spacing len 7", cyc - last, 7);
            check("R1 index restart", int'(start_id), EXP_ID[k]);
            last = cyc;
            task_done = 6'(1) << (EXP_ID[k] - 1);
            @(negedge clk);
            task_done = '0;
        end

        // frame length below 2 acts as 2 (R2)
        do_reset(1);
        rst_n = 1'b1;
        last = cyc;
        wait_strobe("R2 strobe missing");
        check("R2 min frame first", cyc - last, 2);
        last = cyc;
        wait_strobe("R2 strobe missing");
        check("R2 min frame spacing", cyc - last, 2);

        // idle entry and 3-frame wrap on the alternate table (R5, R3, R10)
        do_reset(3);
        rst_n = 1'b1;
        alt_n = 0;
        for (int n = 1; n <= 19; n++) begin
            @(negedge clk);
            if (alt_vld) begin
                if (alt_n < 8) alt_ids[alt_n] = int'(alt_id);
                alt_n++;
            end
            if (n == 7) check("R10 id held through idle frame", int'(alt_id), 2);
            if (n == 6) check("R5 no strobe on idle frame", int'(alt_vld), 0);
        end
        check("R5 strobe count", alt_n, 4);
        check("R3 wrap id0", alt_ids[0], 2);
        check("R3 wrap id1", alt_ids[1], 1);
        check("R3 wrap id2", alt_ids[2], 2);
        check("R3 wrap id3", alt_ids[3], 1);
        check("R5 idle no overrun", int'(alt_ovr), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule